// File: doc/BRIEF.md
# Three-wire serial EEPROM device interface

This block is the device side of a small word-organised serial EEPROM. A host selects it with a chip-select line, clocks a frame in on a data line with a slow serial clock, and reads results back on a data output with its own output enable. The block decodes the frame and performs a word read, a word write, a word erase, or one of two commands that set and clear the internal write-enable latch. The storage is an on-chip array of registers. Writes and erases start a self-timed programming cycle with a programmable length, and while it runs the block reports busy or ready on the data output.

The serial pins are oversampled by the block's own system clock, so the whole design runs in one clock domain. A separate write-control input, `wr_allow`, must be high for a write or erase to change the array. This is independent of the write-enable latch. The block also enforces a minimum number of system clocks with chip select low between two selections. A selection that follows too short a gap is ignored completely.

Top module: `mw_eeprom`

## Requirements
- R1: `di` is sampled on rising `sk` edges while `cs` is high. A frame is a 1 start bit (leading 0 bits are skipped), then a 2-bit opcode, then a 6-bit address, each MSB first. The opcodes are READ=10, WRITE=01 and ERASE=11. Opcode 00 means enable writes when address bits [5:4]=11 and disable writes when they are 00.
- R2: After a READ frame `dout_en` is high. `dout` first gives one 0 bit and then the 16-bit word MSB first. Each bit changes only after a falling `sk` edge and holds while `sk` is high.
- R3: While `cs` is low, `dout_en` is low (the output is high impedance). The delay is one system clock for synchronisation.
- R4: After reset `dout_en` is low, the write-enable latch is cleared and every word reads as 16'hFFFF.
- R5: A WRITE frame is followed by 16 data bits, MSB first. Lowering `cs` after the full frame stores the word.
- R6: A completed ERASE sets every bit of the addressed word to 1.
- R7: WRITE and ERASE change nothing and start no programming cycle unless the latch is set and `wr_allow` is high when `cs` falls. A disable-writes frame clears the latch.
- R8: `wr_allow` has no effect on READ or on the enable-writes and disable-writes frames.
- R9: An accepted WRITE or ERASE is busy for `PROG_CYCLES` clocks. If `cs` is raised during that time, `dout_en` is high and `dout` is 0 while busy and 1 once ready. Frames clocked in while busy are ignored.
- R10: If `cs` falls before a frame is complete, the frame is dropped. The array does not change and no programming cycle starts.
- R11: If `cs` was low for fewer than `CS_GAP` clocks, the next selection is ignored. It gives no output and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data input |
| wr_allow | input | 1 | Write control; must be high for WRITE or ERASE to take effect |
| dout | output | 1 | Serial data output: read data or ready/busy status |
| dout_en | output | 1 | Output enable for `dout`; low means high impedance |

## Verification
The hardest case to reach from the ports is a frame that arrives while the programming cycle is still running. It has to be clocked in completely within the busy window, and its loss must be visible afterwards. The bench makes the cycle longer than a whole write frame. It issues a second write right after an accepted one, waits for ready, and reads the second address to show it still holds the erased value. Short chip-select gaps are produced by dropping `cs` for a single clock before a frame. Aborted frames are produced by lowering `cs` in the middle of the data field.

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter int PROG_CYCLES = 100000,
  parameter int CS_GAP      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic wr_allow,
  output logic dout,
  output logic dout_en
);
  localparam int WORDS = 1 << AW;
  localparam int HW    = AW + 2;
  localparam int BW    = $clog2((DW > HW) ? DW : HW) + 1;
  localparam int CW    = $clog2(PROG_CYCLES + 1);
  localparam int GW    = $clog2(CS_GAP + 1);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_DATA, S_RD, S_PEND, S_HOLD} st_t;

  logic s_cs, s_cs_d, s_sk, s_sk_d, s_di;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s_cs, s_cs_d, s_sk, s_sk_d, s_di} <= '0;
    else begin
      s_cs <= cs;  s_cs_d <= s_cs;
      s_sk <= sk;  s_sk_d <= s_sk;
      s_di <= di;
    end

  wire sk_rise = s_sk & ~s_sk_d;
  wire sk_fall = ~s_sk & s_sk_d;
  wire cs_rise = s_cs & ~s_cs_d;
  wire cs_fall = ~s_cs & s_cs_d;

  st_t              st;
  logic [BW-1:0]    cnt;
  logic [HW-1:0]    hdr;
  logic [DW-1:0]    sh;
  logic [AW-1:0]    addr;
  logic             is_erase, wen, stat, dout_r, sel_ok;
  logic [GW-1:0]    gap_cnt;
  logic [CW-1:0]    prog_cnt;
  logic [DW-1:0]    mem [WORDS];

  wire gap_met = gap_cnt >= GW'(CS_GAP);
  wire sel     = s_cs & (cs_rise ? gap_met : sel_ok);
  wire busy    = prog_cnt != '0;
  wire act     = sel & ~busy;

  wire [HW-1:0] hdr_nx   = {hdr[HW-2:0], s_di};
  wire [AW-1:0] ad_nx    = hdr_nx[AW-1:0];
  wire          hdr_done = act & sk_rise & (st == S_HDR) & (cnt == BW'(HW-1));
  wire          commit   = cs_fall & (st == S_PEND) & wen & wr_allow;
  wire          rd_mode  = st == S_RD;
  wire          fall_evt = act & sk_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  cnt <= '0;  hdr <= '0;  sh <= '0;  addr <= '0;
      is_erase <= 1'b0;  wen <= 1'b0;  stat <= 1'b0;  dout_r <= 1'b0;
      gap_cnt <= GW'(CS_GAP);  sel_ok <= 1'b0;  prog_cnt <= '0;
    end else begin
      if (busy) prog_cnt <= prog_cnt - 1'b1;

      if (!s_cs) begin
        st   <= S_IDLE;
        stat <= 1'b0;
        if (cs_fall)       gap_cnt <= GW'(1);
        else if (!gap_met) gap_cnt <= gap_cnt + 1'b1;
        if (commit) prog_cnt <= CW'(PROG_CYCLES);
      end

      if (cs_rise) begin
        sel_ok <= gap_met;
        stat   <= gap_met & busy;
      end

      if (act && sk_rise) begin
        case (st)
          S_IDLE: if (s_di) begin
            st <= S_HDR;  cnt <= '0;  stat <= 1'b0;
          end
          S_HDR: begin
            hdr <= hdr_nx;
            cnt <= cnt + 1'b1;
            if (cnt == BW'(HW-1)) begin
              addr <= ad_nx;
              cnt  <= '0;
              case (hdr_nx[HW-1:HW-2])
                2'b10: begin st <= S_RD;   sh <= mem[ad_nx]; dout_r <= 1'b0; end
                2'b01: begin st <= S_DATA; is_erase <= 1'b0; end
                2'b11: begin st <= S_PEND; is_erase <= 1'b1; end
                default: begin
                  st <= S_HOLD;
                  if (ad_nx[AW-1:AW-2] == 2'b11)      wen <= 1'b1;
                  else if (ad_nx[AW-1:AW-2] == 2'b00) wen <= 1'b0;
                end
              endcase
            end
          end
          S_DATA: begin
            sh  <= {sh[DW-2:0], s_di};
            cnt <= cnt + 1'b1;
            if (cnt == BW'(DW-1)) st <= S_PEND;
          end
          default: ;
        endcase
      end

      if (fall_evt && rd_mode) begin
        if (cnt == '0) begin
          dout_r <= 1'b0;
          cnt    <= BW'(1);
        end else begin
          dout_r <= sh[DW-1];
          sh     <= {sh[DW-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (commit) begin
      mem[addr] <= is_erase ? '1 : sh;
    end

  assign dout    = stat ? ~busy : dout_r;
  assign dout_en = sel & (stat | rd_mode);
endmodule

module mw_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic wr_allow,
  input logic dout_en,
  input logic dout_r,
  input logic wen,
  input logic busy,
  input logic stat,
  input logic rd_mode,
  input logic fall_evt,
  input logic hdr_done
);
  // R3
  hiz_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs && $past(!cs)) |-> !dout_en);

  // R2
  read_bit_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode && $past(rd_mode) && !$past(fall_evt)) |-> $stable(dout_r));

  // R7
  prog_needs_permission_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(wr_allow) && $past(wen)));

  // R1
  latch_moves_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(wen) |-> $past(hdr_done));

  // R9
  busy_shows_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && busy) |-> stat);
endmodule

bind mw_eeprom mw_eeprom_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs(cs), .wr_allow(wr_allow),
  .dout_en(dout_en), .dout_r(dout_r), .wen(wen), .busy(busy),
  .stat(stat), .rd_mode(rd_mode), .fall_evt(fall_evt), .hdr_done(hdr_done)
);

// File: tb/mw_eeprom_tb_top.sv
module mw_eeprom_tb_top;
  localparam int PROG = 400;
  localparam int GAP  = 4;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, wr_allow = 1'b1;
  logic dout, dout_en;
  int n_chk = 0, n_fail = 0;

  logic [16:0] exp_q[$];
  logic [16:0] act_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  mw_eeprom #(.AW(6), .DW(16), .PROG_CYCLES(PROG), .CS_GAP(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .wr_allow(wr_allow), .dout(dout), .dout_en(dout_en)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bit_out(logic b);
    sk = 1'b0; di = b; tick(HALF);
    sk = 1'b1; tick(HALF);
  endtask

  task automatic start_frame(logic [1:0] op, logic [5:0] a);
    cs = 1'b1; tick(2);
    bit_out(1'b0);
    bit_out(1'b1);
    bit_out(op[1]); bit_out(op[0]);
    for (int i = 5; i >= 0; i--) bit_out(a[i]);
  endtask

  task automatic end_frame();
    sk = 1'b0; tick(HALF);
    cs = 1'b0; tick(8);
  endtask

  task automatic write_word(logic [5:0] a, logic [15:0] d);
    start_frame(2'b01, a);
    for (int i = 15; i >= 0; i--) bit_out(d[i]);
    end_frame();
  endtask

  task automatic read_word(logic [5:0] a, logic [15:0] exp, string tag);
    logic [16:0] got;
    logic b;
    bit unstable, dark;
    got = '0; unstable = 0; dark = 0;
    exp_q.push_back({1'b0, exp});
    tag_q.push_back(tag);
    start_frame(2'b10, a);
    for (int i = 0; i < 17; i++) begin
      sk = 1'b0; tick(HALF);
      b = dout;
      if (!dout_en) dark = 1;
      got = {got[15:0], b};
      sk = 1'b1; tick(HALF - 1);
      if (dout !== b) unstable = 1;
      tick(1);
    end
    end_frame();
    check(!unstable, "R2 bit held while sk high", {31'd0, unstable}, 32'd0);
    check(!dark, "R2 dout_en during read", {31'd0, dark}, 32'd0);
    act_q.push_back(got);
  endtask

  task automatic no_busy(string tag);
    cs = 1'b1; tick(3);
    check(dout_en == 1'b0, tag, {31'd0, dout_en}, 32'd0);
    cs = 1'b0; tick(8);
  endtask

  initial begin : monitor
    logic [16:0] a, e;
    string t;
    forever begin
      wait (act_q.size() != 0);
      a = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(a === e, t, {15'd0, a}, {15'd0, e});
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin : driver
    bit seen;
    tick(5); rst_n = 1'b1; tick(5);
    check(dout_en == 1'b0, "R4 reset dout_en", {31'd0, dout_en}, 32'd0);
    read_word(6'd0, 16'hFFFF, "R4 reset array");

    write_word(6'd3, 16'h1234);
    no_busy("R7 write without latch no busy");
    read_word(6'd3, 16'hFFFF, "R7 write without latch");

    wr_allow = 1'b0;
    start_frame(2'b00, 6'b110000); end_frame();
    write_word(6'd3, 16'h1234);
    read_word(6'd3, 16'hFFFF, "R7 write blocked by wr_allow");
    read_word(6'd0, 16'hFFFF, "R8 read with wr_allow low");

    wr_allow = 1'b1;
    write_word(6'd5, 16'hA5C3);
    cs = 1'b1; tick(3);
    check(dout_en && dout == 1'b0, "R9 busy status", {30'd0, dout_en, dout}, 32'h2);
    tick(PROG);
    check(dout_en && dout == 1'b1, "R9 ready status", {30'd0, dout_en, dout}, 32'h3);
    cs = 1'b0; tick(2);
    check(dout_en == 1'b0, "R3 hiz after cs low", {31'd0, dout_en}, 32'd0);
    tick(8);
    read_word(6'd5, 16'hA5C3, "R5 R8 write after enable with wr_allow low");

    write_word(6'd63, 16'h1234);
    tick(PROG + 20);
    read_word(6'd63, 16'h1234, "R1 top address");
    read_word(6'd62, 16'hFFFF, "R1 neighbour untouched");

    write_word(6'd10, 16'h0F0F);
    write_word(6'd11, 16'h0000);
    tick(PROG);
    read_word(6'd10, 16'h0F0F, "R5 data pattern");
    read_word(6'd11, 16'hFFFF, "R9 frame during busy ignored");

    start_frame(2'b11, 6'd5); end_frame();
    tick(PROG + 20);
    read_word(6'd5, 16'hFFFF, "R6 erase");

    start_frame(2'b01, 6'd7);
    for (int i = 0; i < 10; i++) bit_out(1'b0);
    end_frame();
    no_busy("R10 abort no busy");
    read_word(6'd7, 16'hFFFF, "R10 abort no change");

    cs = 1'b1; tick(2); cs = 1'b0; tick(1);
    write_word(6'd20, 16'h0000);
    no_busy("R11 short gap write no busy");
    read_word(6'd20, 16'hFFFF, "R11 short gap write ignored");

    cs = 1'b1; tick(2); cs = 1'b0; tick(1);
    seen = 0;
    start_frame(2'b10, 6'd10);
    for (int i = 0; i < 17; i++) begin
      sk = 1'b0; tick(HALF);
      if (dout_en) seen = 1;
      sk = 1'b1; tick(HALF);
    end
    end_frame();
    check(!seen, "R11 short gap read silent", {31'd0, seen}, 32'd0);

    wr_allow = 1'b0;
    start_frame(2'b00, 6'b000000); end_frame();
    wr_allow = 1'b1;
    write_word(6'd63, 16'h0000);
    no_busy("R7 write after disable no busy");
    read_word(6'd63, 16'h1234, "R7 R8 disable with wr_allow low");

    wait (act_q.size() == 0);
    tick(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule